// File: doc/BRIEF.md
# CIP header receive checker

This block sits behind an isochronous receive path and checks one packet header at a time. For each packet it takes three 32-bit quadlets: the isochronous header, which carries the payload length, and the two quadlets of the common isochronous packet (CIP) header. It checks them against a static configuration: the expected SPH bit, the expected format code, the largest payload length allowed, and two mode flags. On success it reports the number of data blocks in the payload, the data block counter (DBC) and the SYT timestamp field. If a check fails, it reports an error code instead and sets a sticky error flag.

The number of blocks comes from dividing the payload quadlets, minus the two header quadlets, by the advertised block size. A sequential divider does the division, so a packet takes several cycles. `busy` is high for that time and `done` pulses for one cycle when the result is ready.

A continuity tracker holds counter state from one packet to the next. It supports two counter conventions: in one the DBC numbers the first event of the packet, in the other it numbers the last. A `restart` pulse marks the start of a new stream. It makes the counter unknown again and clears the sticky flag.

Top module: `cip_rx_check`

## Requirements
- R1: The payload length is `iso_hdr[31:16]` in bytes. A length greater than `cfg_max_len` finishes with `err_code` 1 (oversize). This check has the highest priority, and a length equal to the limit is accepted.
- R2: Bit 31 of `cip_q0` must be 0 and bit 31 of `cip_q1` must be 1, otherwise `err_code` is 2. While `cfg_skip_eoh` is 1 these two bits are not checked.
- R3: If `cip_q0[10]` differs from `cfg_sph`, or `cip_q1[29:24]` differs from `cfg_fmt`, `err_code` is 3.
- R4: A packet has zero data blocks when its length is below 8 bytes, or when the format is 0x10 and `cip_q1[23:16]` is 0xFF. In that case the block size is not checked.
- R5: The block size is `cip_q0[23:16]`. A block size of 0 gives `err_code` 4. Otherwise `blocks` = floor((floor(length/4) − 2) / block size).
- R6: On success `dbc` shows `cip_q0[7:0]`, `syt` shows `cip_q1[15:0]`, and `err_code` is 0. The error codes are checked in the order 1, 2, 3, 4, 5, and the first one that applies is reported.
- R7: The first packet after reset or `restart` is accepted without a continuity check, and it sets the tracker.
- R8: With `cfg_dbc_last` = 0, the DBC must equal the stored expected value, otherwise `err_code` is 5. An accepted packet sets the expected value to (DBC + blocks) mod 256.
- R9: With `cfg_dbc_last` = 1, the DBC must equal (previous accepted DBC + blocks) mod 256, otherwise `err_code` is 5.
- R10: On any error, `blocks`, `dbc` and `syt` keep their earlier values, the tracker does not change, and `err_sticky` is set.
- R11: `done` pulses for exactly one cycle at the end of each packet, after `busy` has been high. While `busy` is high, `hdr_valid` is ignored.
- R12: `restart` clears `err_sticky` and makes the counter unknown, unless an error finishes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| restart | input | 1 | New stream: counter becomes unknown, sticky flag clears |
| hdr_valid | input | 1 | The three header quadlets are valid this cycle |
| iso_hdr | input | 32 | Isochronous header quadlet |
| cip_q0 | input | 32 | First CIP header quadlet |
| cip_q1 | input | 32 | Second CIP header quadlet |
| cfg_sph | input | 1 | Expected SPH bit |
| cfg_fmt | input | 6 | Expected format code |
| cfg_max_len | input | 16 | Largest accepted payload length in bytes |
| cfg_skip_eoh | input | 1 | Skip the check of the end-of-header bits |
| cfg_dbc_last | input | 1 | 1: DBC numbers the last event; 0: the first event |
| busy | output | 1 | A packet is being processed |
| done | output | 1 | One-cycle pulse: result ready |
| blocks | output | 14 | Data blocks in the last accepted packet |
| dbc | output | 8 | DBC of the last accepted packet |
| syt | output | 16 | SYT of the last accepted packet |
| err_code | output | 3 | Result of the last packet: 0 ok, 1 oversize, 2 end-of-header, 3 protocol, 4 zero block size, 5 gap |
| err_sticky | output | 1 | An error has occurred since the last restart |

## Verification
The hardest case to reach is a counter that wraps past 255. In the last-event convention this only happens when the block count itself is large, and the tracker must already hold a known value near the top of the range. The stimulus table first builds up tracker state with a chain of accepted packets. It then sends a 174-block packet whose DBC lands only after the wrap, and a first-event sequence that starts at 0xFE. A second hard case is a header presented while the divider is still running. A directed test drives it one cycle after acceptance, then checks that only one result appears and that the tracker advanced by the first packet alone.

// File: rtl/cip_rx_pkg.sv
package cip_rx_pkg;

    localparam int LEN_W   = 16;          // width of the payload length field
    localparam int BLK_W   = LEN_W - 2;   // quadlet count width, also block count width
    localparam int DBS_W   = 8;
    localparam int DBC_W   = 8;
    localparam int SYT_W   = 16;
    localparam int FMT_W   = 6;

    localparam logic [FMT_W-1:0] FMT_AUDIO  = 6'h10;
    localparam logic [7:0]       FDF_EMPTY  = 8'hFF;
    localparam logic [LEN_W-1:0] MIN_CIP_LEN = 16'd8;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_OVERSIZE = 3'd1,
        ERR_EOH      = 3'd2,
        ERR_PROTO    = 3'd3,
        ERR_DBS      = 3'd4,
        ERR_GAP      = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_FINISH = 2'd3
    } st_e;

endpackage

// File: rtl/cip_hdr_decode.sv
module cip_hdr_decode
    import cip_rx_pkg::*;
(
    input  logic [31:0]      iso_hdr,
    input  logic [31:0]      q0,
    input  logic [31:0]      q1,
    input  logic             cfg_sph,
    input  logic [FMT_W-1:0] cfg_fmt,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             cfg_skip_eoh,
    output err_e             pre_err,
    output logic             no_data,
    output logic [BLK_W-1:0] dividend,
    output logic [DBS_W-1:0] dbs,
    output logic [DBC_W-1:0] dbc,
    output logic [SYT_W-1:0] syt
);

    logic [LEN_W-1:0] len;
    logic [BLK_W-1:0] quads;
    logic [FMT_W-1:0] fmt_rx;
    logic [7:0]       fdf_rx;
    logic             short_pkt;
    logic             eoh_bad;
    logic             proto_bad;
    logic             unused_bits;

    assign unused_bits = ^{iso_hdr[15:0], q0[30:24], q0[15:11], q0[9:8], q1[30]};

    always_comb begin
        len       = iso_hdr[31:16];
        quads     = len[LEN_W-1:2];
        fmt_rx    = q1[29:24];
        fdf_rx    = q1[23:16];
        dbs       = q0[23:16];
        dbc       = q0[7:0];
        syt       = q1[15:0];
        short_pkt = (len < MIN_CIP_LEN);
        no_data   = short_pkt || ((fmt_rx == FMT_AUDIO) && (fdf_rx == FDF_EMPTY));
        eoh_bad   = (q0[31] || !q1[31]) && !cfg_skip_eoh;
        proto_bad = (q0[10] != cfg_sph) || (fmt_rx != cfg_fmt);
        dividend  = short_pkt ? '0 : (quads - BLK_W'(2));

        if (len > cfg_max_len)
            pre_err = ERR_OVERSIZE;
        else if (eoh_bad)
            pre_err = ERR_EOH;
        else if (proto_bad)
            pre_err = ERR_PROTO;
        else if (!no_data && (dbs == '0))
            pre_err = ERR_DBS;
        else
            pre_err = ERR_NONE;
    end

endmodule

// File: rtl/cip_seq_div.sv
module cip_seq_div #(
    parameter int NUM_W = 14,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic             done;
    } div_t;

    div_t d_d, d_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           ge;

    always_comb begin
        d_d      = d_q;
        d_d.done = 1'b0;
        trial    = {d_q.rem, d_q.quo[NUM_W-1]};
        diff     = trial - {1'b0, den};
        ge       = (trial >= {1'b0, den});
        if (start) begin
            d_d.cnt = CNT_W'(NUM_W);
            d_d.rem = '0;
            d_d.quo = num;
        end else if (d_q.cnt != '0) begin
            d_d.quo = {d_q.quo[NUM_W-2:0], ge};
            d_d.rem = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            d_d.cnt = d_q.cnt - CNT_W'(1);
            if (d_q.cnt == CNT_W'(1))
                d_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            d_q <= '0;
        else
            d_q <= d_d;
    end

    assign quo  = d_q.quo;
    assign done = d_q.done;

endmodule

// File: rtl/cip_dbc_track.sv
module cip_dbc_track #(
    parameter int DBC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             commit,
    input  logic             mode_last,
    input  logic [DBC_W-1:0] dbc_in,
    input  logic [DBC_W-1:0] blk_lo,
    output logic             in_seq
);

    typedef struct packed {
        logic             known;
        logic [DBC_W-1:0] ref_val;
    } trk_t;

    trk_t t_d, t_q;
    logic [DBC_W-1:0] want;

    always_comb begin
        want   = mode_last ? (t_q.ref_val + blk_lo) : t_q.ref_val;
        in_seq = !t_q.known || (dbc_in == want);

        t_d = t_q;
        if (restart) begin
            t_d.known = 1'b0;
        end else if (commit) begin
            t_d.known   = 1'b1;
            t_d.ref_val = mode_last ? dbc_in : (dbc_in + blk_lo);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            t_q <= '0;
        else
            t_q <= t_d;
    end

endmodule

// File: rtl/cip_rx_check.sv
module cip_rx_check
    import cip_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             hdr_valid,
    input  logic [31:0]      iso_hdr,
    input  logic [31:0]      cip_q0,
    input  logic [31:0]      cip_q1,
    input  logic             cfg_sph,
    input  logic [5:0]       cfg_fmt,
    input  logic [15:0]      cfg_max_len,
    input  logic             cfg_skip_eoh,
    input  logic             cfg_dbc_last,
    output logic             busy,
    output logic             done,
    output logic [13:0]      blocks,
    output logic [7:0]       dbc,
    output logic [15:0]      syt,
    output logic [2:0]       err_code,
    output logic             err_sticky
);

    typedef struct packed {
        st_e              st;
        logic [31:0]      iso;
        logic [31:0]      q0;
        logic [31:0]      q1;
        err_e             fin_err;
        logic [BLK_W-1:0] work;
        logic [BLK_W-1:0] blocks;
        logic [DBC_W-1:0] dbc;
        logic [SYT_W-1:0] syt;
        err_e             code;
        logic             sticky;
        logic             done;
    } top_t;

    top_t s_d, s_q;

    err_e             dec_err;
    logic             dec_no_data;
    logic [BLK_W-1:0] dec_dividend;
    logic [DBS_W-1:0] dec_dbs;
    logic [DBC_W-1:0] dec_dbc;
    logic [SYT_W-1:0] dec_syt;
    logic             div_start;
    logic [BLK_W-1:0] div_quo;
    logic             div_done;
    logic             trk_commit;
    logic             trk_in_seq;
    err_e             final_err;

    cip_hdr_decode u_decode (
        .iso_hdr      (s_q.iso),
        .q0           (s_q.q0),
        .q1           (s_q.q1),
        .cfg_sph      (cfg_sph),
        .cfg_fmt      (cfg_fmt),
        .cfg_max_len  (cfg_max_len),
        .cfg_skip_eoh (cfg_skip_eoh),
        .pre_err      (dec_err),
        .no_data      (dec_no_data),
        .dividend     (dec_dividend),
        .dbs          (dec_dbs),
        .dbc          (dec_dbc),
        .syt          (dec_syt)
    );

    cip_seq_div #(
        .NUM_W (BLK_W),
        .DEN_W (DBS_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (dec_dividend),
        .den   (dec_dbs),
        .quo   (div_quo),
        .done  (div_done)
    );

    cip_dbc_track #(
        .DBC_W (DBC_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .commit    (trk_commit),
        .mode_last (cfg_dbc_last),
        .dbc_in    (dec_dbc),
        .blk_lo    (s_q.work[DBC_W-1:0]),
        .in_seq    (trk_in_seq)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.sticky = s_q.sticky & ~restart;
        div_start  = 1'b0;
        trk_commit = 1'b0;
        final_err  = s_q.fin_err;

        unique case (s_q.st)
            ST_IDLE: begin
                if (hdr_valid) begin
                    s_d.iso = iso_hdr;
                    s_d.q0  = cip_q0;
                    s_d.q1  = cip_q1;
                    s_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                s_d.work    = '0;
                s_d.fin_err = dec_err;
                if (dec_err != ERR_NONE || dec_no_data) begin
                    s_d.st = ST_FINISH;
                end else begin
                    div_start = 1'b1;
                    s_d.st    = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    s_d.work = div_quo;
                    s_d.st   = ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (s_q.fin_err == ERR_NONE && !trk_in_seq)
                    final_err = ERR_GAP;
                if (final_err == ERR_NONE) begin
                    trk_commit = 1'b1;
                    s_d.blocks = s_q.work;
                    s_d.dbc    = dec_dbc;
                    s_d.syt    = dec_syt;
                end else begin
                    s_d.sticky = 1'b1;
                end
                s_d.code = final_err;
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;
    assign blocks     = s_q.blocks;
    assign dbc        = s_q.dbc;
    assign syt        = s_q.syt;
    assign err_code   = s_q.code;
    assign err_sticky = s_q.sticky;

endmodule

// File: rtl/cip_rx_check_sva.sv
module cip_rx_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        restart,
    input logic        busy,
    input logic        done,
    input logic [13:0] blocks,
    input logic [7:0]  dbc,
    input logic [15:0] syt,
    input logic [2:0]  err_code,
    input logic        err_sticky
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R11

    AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 3'd0) |->
        (blocks == $past(blocks) && dbc == $past(dbc) && syt == $past(syt))); // R10

    AST_ERR_RAISES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 3'd0) |-> err_sticky); // R10

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !restart) |=> err_sticky); // R10

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!err_sticky || (done && err_code != 3'd0))); // R12

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code <= 3'd5)); // R6

endmodule

bind cip_rx_check cip_rx_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .busy       (busy),
    .done       (done),
    .blocks     (blocks),
    .dbc        (dbc),
    .syt        (syt),
    .err_code   (err_code),
    .err_sticky (err_sticky)
);

// File: tb/tb_cip_rx_check.sv
`timescale 1ns/1ps
module tb_cip_rx_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [31:0] iso_hdr = '0;
    logic [31:0] cip_q0 = '0;
    logic [31:0] cip_q1 = '0;
    logic        cfg_sph = 1'b0;
    logic [5:0]  cfg_fmt = 6'h10;
    logic [15:0] cfg_max_len = 16'h0400;
    logic        cfg_skip_eoh = 1'b0;
    logic        cfg_dbc_last = 1'b0;
    logic        busy, done, err_sticky;
    logic [13:0] blocks;
    logic [7:0]  dbc;
    logic [15:0] syt;
    logic [2:0]  err_code;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cip_rx_check dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .hdr_valid(hdr_valid),
        .iso_hdr(iso_hdr), .cip_q0(cip_q0), .cip_q1(cip_q1),
        .cfg_sph(cfg_sph), .cfg_fmt(cfg_fmt), .cfg_max_len(cfg_max_len),
        .cfg_skip_eoh(cfg_skip_eoh), .cfg_dbc_last(cfg_dbc_last),
        .busy(busy), .done(done), .blocks(blocks), .dbc(dbc), .syt(syt),
        .err_code(err_code), .err_sticky(err_sticky)
    );

    typedef struct packed {
        logic        rst;
        logic        mlast;
        logic        skip;
        logic [15:0] len;
        logic        e0;
        logic        e1;
        logic        sph;
        logic [5:0]  fmt;
        logic [7:0]  fdf;
        logic [7:0]  dbs;
        logic [7:0]  dbc;
        logic [15:0] syt;
        logic [2:0]  code;
        logic [13:0] blk;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h10,16'h1234,3'd0,14'd4},   // R7 R5
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h14,16'h2345,3'd0,14'd4},   // R8
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h20,16'h3456,3'd5,14'd0},   // R8 gap
        '{1'b0,1'b0,1'b0,16'd8,   1'b0,1'b1,1'b0,6'h10,8'hFF,8'd2,8'h18,16'hFFFF,3'd0,14'd0},   // R4
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd0,8'h18,16'h4567,3'd4,14'd0},   // R5 dbs 0
        '{1'b0,1'b0,1'b0,16'd70,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd3,8'h18,16'h5678,3'd0,14'd5},   // R5 floor
        '{1'b0,1'b0,1'b0,16'd1028,1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h1D,16'h6789,3'd1,14'd0},   // R1
        '{1'b0,1'b0,1'b0,16'd40,  1'b1,1'b1,1'b0,6'h10,8'h00,8'd2,8'h1D,16'h789A,3'd2,14'd0},   // R2
        '{1'b0,1'b0,1'b1,16'd40,  1'b1,1'b0,1'b0,6'h10,8'h00,8'd2,8'h1D,16'h89AB,3'd0,14'd4},   // R2 waived
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b1,6'h10,8'h00,8'd2,8'h21,16'h9ABC,3'd3,14'd0},   // R3 sph
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h11,8'h00,8'd2,8'h21,16'hABCD,3'd3,14'd0},   // R3 fmt
        '{1'b0,1'b0,1'b0,16'd4,   1'b0,1'b1,1'b0,6'h10,8'h00,8'd0,8'h21,16'hBCDE,3'd0,14'd0},   // R4 short
        '{1'b1,1'b0,1'b0,16'd24,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd1,8'hFE,16'hCDEF,3'd0,14'd4},   // R7
        '{1'b0,1'b0,1'b0,16'd8,   1'b0,1'b1,1'b0,6'h10,8'h00,8'd1,8'h02,16'h0111,3'd0,14'd0},   // R8 wrap
        '{1'b1,1'b1,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h50,16'h0222,3'd0,14'd4},   // R7 R9
        '{1'b0,1'b1,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h54,16'h0333,3'd0,14'd4},   // R9
        '{1'b0,1'b1,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd2,8'h54,16'h0444,3'd5,14'd0},   // R9 gap
        '{1'b0,1'b1,1'b0,16'd8,   1'b0,1'b1,1'b0,6'h10,8'hFF,8'd2,8'h54,16'h0555,3'd0,14'd0},   // R9 empty
        '{1'b0,1'b1,1'b0,16'd704, 1'b0,1'b1,1'b0,6'h10,8'h00,8'd1,8'h02,16'h0666,3'd0,14'd174}, // R9 wrap
        '{1'b1,1'b1,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd4,8'h33,16'h0777,3'd0,14'd2},   // R7
        '{1'b1,1'b0,1'b0,16'd1024,1'b0,1'b1,1'b0,6'h10,8'h00,8'd1,8'h00,16'h0888,3'd0,14'd254}, // R1 limit
        '{1'b0,1'b0,1'b0,16'd40,  1'b0,1'b1,1'b0,6'h10,8'h00,8'd7,8'hFE,16'h0999,3'd0,14'd1}    // R5 R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic drive(input logic [15:0] len, input logic e0, input logic e1,
                         input logic sph, input logic [5:0] fmt, input logic [7:0] fdf,
                         input logic [7:0] dbs, input logic [7:0] dv, input logic [15:0] sv);
        iso_hdr = {len, 16'h0000};
        cip_q0  = {e0, 7'd0, dbs, 5'd0, sph, 2'd0, dv};
        cip_q1  = {e1, 1'b0, fmt, fdf, sv};
    endtask

    task automatic wait_done(input string req, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!seen) check(req, 32'd0, 32'd1);
    endtask

    logic [13:0] last_blk = '0;
    logic [7:0]  last_dbc = '0;
    logic [15:0] last_syt = '0;
    logic        sticky_exp = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R11 actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic seen;
        int   dones;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R11 reset busy", {31'd0, busy}, 32'd0);
        check("R11 reset done", {31'd0, done}, 32'd0);
        check("R6 reset blocks", {18'd0, blocks}, 32'd0);
        check("R6 reset dbc/syt", {8'd0, dbc, syt}, 32'd0);
        check("R10 reset code/sticky", {28'd0, err_code, err_sticky}, 32'd0);

        // table of vectors
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rst) begin
                pulse_restart();
                sticky_exp = 1'b0;
            end
            @(negedge clk);
            cfg_dbc_last = VEC[k].mlast;
            cfg_skip_eoh = VEC[k].skip;
            drive(VEC[k].len, VEC[k].e0, VEC[k].e1, VEC[k].sph, VEC[k].fmt,
                  VEC[k].fdf, VEC[k].dbs, VEC[k].dbc, VEC[k].syt);
            hdr_valid = 1'b1;
            @(negedge clk);
            hdr_valid = 1'b0;
            wait_done("R11 done timeout", seen);
            if (seen) begin
                if (VEC[k].code == 3'd0) begin
                    last_blk = VEC[k].blk;
                    last_dbc = VEC[k].dbc;
                    last_syt = VEC[k].syt;
                end else begin
                    sticky_exp = 1'b1;
                end
                check($sformatf("R6 code vec %0d", k), {29'd0, err_code}, {29'd0, VEC[k].code});
                check($sformatf("R5 blocks vec %0d", k), {18'd0, blocks}, {18'd0, last_blk});
                check($sformatf("R6 dbc vec %0d", k), {24'd0, dbc}, {24'd0, last_dbc});
                check($sformatf("R6 syt vec %0d", k), {16'd0, syt}, {16'd0, last_syt});
                check($sformatf("R10 sticky vec %0d", k), {31'd0, err_sticky}, {31'd0, sticky_exp});
            end
        end
        cfg_skip_eoh = 1'b0;
        cfg_dbc_last = 1'b0;

        // R10 / R12: error then restart clears the sticky flag
        @(negedge clk);
        drive(16'd2000, 1'b0, 1'b1, 1'b0, 6'h10, 8'h00, 8'd2, 8'h00, 16'h1111);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        wait_done("R1 done timeout", seen);
        check("R1 oversize code", {29'd0, err_code}, 32'd1);
        check("R10 sticky after error", {31'd0, err_sticky}, 32'd1);
        check("R10 dbc held", {24'd0, dbc}, {24'd0, last_dbc});
        pulse_restart();
        @(negedge clk);
        check("R12 sticky cleared", {31'd0, err_sticky}, 32'd0);

        // R11: header during busy is ignored; R7 first packet after restart
        @(negedge clk);
        drive(16'd40, 1'b0, 1'b1, 1'b0, 6'h10, 8'h00, 8'd1, 8'h40, 16'hAAAA);
        hdr_valid = 1'b1;
        @(negedge clk);
        drive(16'd12, 1'b0, 1'b1, 1'b0, 6'h10, 8'h00, 8'd1, 8'h99, 16'hBBBB);
        @(negedge clk);
        hdr_valid = 1'b0;
        wait_done("R11 done timeout", seen);
        check("R11 first packet blocks", {18'd0, blocks}, 32'd8);
        check("R11 first packet dbc", {24'd0, dbc}, 32'h40);
        check("R11 first packet syt", {16'd0, syt}, 32'hAAAA);
        dones = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R11 no second result", dones, 32'd0);

        // R8: tracker advanced by the accepted packet only (0x40 + 8)
        drive(16'd12, 1'b0, 1'b1, 1'b0, 6'h10, 8'h00, 8'd1, 8'h48, 16'hCCCC);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        wait_done("R8 done timeout", seen);
        check("R8 continuity after ignored header", {29'd0, err_code}, 32'd0);
        check("R8 blocks", {18'd0, blocks}, 32'd1);

        // R3: protocol error outranks block-size error
        @(negedge clk);
        drive(16'd40, 1'b0, 1'b1, 1'b1, 6'h10, 8'h00, 8'd0, 8'h49, 16'hDDDD);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        wait_done("R3 done timeout", seen);
        check("R3 priority over dbs", {29'd0, err_code}, 32'd3);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule